// File: doc/BRIEF.md
# Paged and Dual Pointer External Address Generator

This block forms the 16-bit address used by indirect moves to and from external data memory. It has two modes. In paged mode, the caller supplies the byte held in the working register that the instruction names. That byte becomes the low half of the address, and a page register supplies the high half. The 64 KB space is therefore seen as 256 pages of 256 bytes. In pointer mode, the full address comes from one of two 16-bit data pointers.

A select register chooses the active pointer. Every pointer action uses only the selected pointer: the byte loads, the increment, the read-back and the address output. The unselected pointer keeps its contents, so software can toggle the select bit and switch quickly between a source and a destination pointer during block moves. The bus timing and the opcode decode sit outside the block. The block owns the pointer storage, the selection and the address multiplexing.

Top module: `ext_addr_gen`

## Requirements
- R1: With `addrMode` = 0, `addr` equals {page register, `workReg`}: bits 15:8 come from the page register and bits 7:0 from `workReg`.
- R2: With `addrMode` = 1, `addr` equals the full 16-bit value of the selected data pointer.
- R3: A cycle with `selWe` high loads `wrData[0]` into the select bit. Value 0 selects pointer 0 and value 1 selects pointer 1. `selValue` shows the select bit in bit 0, and its bits 7:1 always read 0.
- R4: `ptrLoWe` writes `wrData` into bits 7:0 and `ptrHiWe` writes it into bits 15:8 of the selected pointer only. Both may be asserted together. `ptrValue` reads back the selected pointer.
- R5: `ptrInc` adds 1 modulo 65536 to the selected pointer, with the carry going from the low byte into the high byte. 0xFFFF becomes 0x0000.
- R6: The unselected pointer never changes. Toggling the select bit away and back returns the previous value unchanged.
- R7: In a cycle that also carries a pointer byte write, `ptrInc` is ignored. A select write in the same cycle as a pointer operation leaves that operation acting on the pointer that was selected before the edge.
- R8: After reset, both pointers, the page register and the select bit are 0.
- R9: `pageWe` loads `wrData` into the page register, which `pageValue` reads back. A page write leaves both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrMode | input | 1 | 0 = paged addressing, 1 = pointer addressing |
| workReg | input | 8 | Working register byte for paged mode |
| wrData | input | 8 | Write data for all register writes |
| ptrLoWe | input | 1 | Write the low byte of the selected pointer |
| ptrHiWe | input | 1 | Write the high byte of the selected pointer |
| ptrInc | input | 1 | Increment the selected pointer |
| pageWe | input | 1 | Write the page register |
| selWe | input | 1 | Write the select register |
| addr | output | 16 | External data address |
| ptrValue | output | 16 | Selected pointer read-back |
| pageValue | output | 8 | Page register read-back |
| selValue | output | 8 | Select register read-back, bits 7:1 zero |

## Verification
The bench sweeps every page value with varied working-register bytes, so a swapped or shifted byte lane in paged mode shows up as a wrong high or low address half. It drives increments across the low-byte carry and across the 0xFFFF wrap, which catches a missing carry or an increment that saturates. It writes the select register with every data byte, which catches any upper bit that leaks into the read-back. It also toggles between pointers after loading distinct values, so a design that lets a load or increment reach the unselected pointer returns the wrong value when the select bit comes back. Same-cycle cases, and a long pseudo-random mix of operations, check that a byte write wins over an increment and that a select write does not redirect the operation in its own cycle.

// File: rtl/xag_pkg.sv
package xag_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic wrLo;    // write low byte of active pointer
    logic wrHi;    // write high byte of active pointer
    logic bump;    // increment active pointer
    logic wrPage;  // write page register
  } xagStrobe_t;

endpackage

// File: rtl/xag_ctrl.sv
module xag_ctrl
  import xag_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ptrLoWe,
  input  logic              ptrHiWe,
  input  logic              ptrInc,
  input  logic              pageWe,
  input  logic              selWe,
  output xagStrobe_t        strobe,
  output logic [IDX_W-1:0]  activeIdx,
  output logic [BYTE_W-1:0] selValue
);

  logic [IDX_W-1:0] selReg;

  // Select register: only the index bits are stored (R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (selWe) begin
      selReg <= wrData[IDX_W-1:0];
    end
  end

  // Pointer ops use the selection held before this edge (R7)
  assign activeIdx = selReg;

  always_comb begin
    strobe.wrLo   = ptrLoWe;
    strobe.wrHi   = ptrHiWe;
    // a byte write takes precedence over an increment (R7)
    strobe.bump   = ptrInc & ~ptrLoWe & ~ptrHiWe;
    strobe.wrPage = pageWe;
  end

  always_comb begin
    selValue             = '0;
    selValue[IDX_W-1:0]  = selReg;
  end

endmodule

// File: rtl/xag_datapath.sv
module xag_datapath
  import xag_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int ADDR_W = 2 * BYTE_W,
  localparam int IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  xagStrobe_t                     strobe,
  input  logic [IDX_W-1:0]               activeIdx,
  input  logic [BYTE_W-1:0]              wrData,
  input  logic                           addrMode,
  input  logic [BYTE_W-1:0]              workReg,
  output logic [ADDR_W-1:0]              addr,
  output logic [ADDR_W-1:0]              ptrValue,
  output logic [BYTE_W-1:0]              pageValue,
  output logic [NUM_PTR-1:0][ADDR_W-1:0] ptrAll
);

  logic [BYTE_W-1:0] pageReg;

  // One storage slice per data pointer
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic hit;
    assign hit = (activeIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrAll[i] <= '0;
      end else if (hit) begin
        if (strobe.bump) begin
          ptrAll[i] <= ptrAll[i] + ADDR_W'(1);
        end else begin
          if (strobe.wrLo) ptrAll[i][BYTE_W-1:0]      <= wrData;
          if (strobe.wrHi) ptrAll[i][ADDR_W-1:BYTE_W] <= wrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
    end else if (strobe.wrPage) begin
      pageReg <= wrData;
    end
  end

  assign ptrValue  = ptrAll[activeIdx];
  assign pageValue = pageReg;
  assign addr      = addrMode ? ptrValue : {pageReg, workReg};

endmodule

// File: rtl/ext_addr_gen.sv
module ext_addr_gen
  import xag_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int ADDR_W = 2 * BYTE_W,
  localparam int IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrMode,
  input  logic [BYTE_W-1:0] workReg,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ptrLoWe,
  input  logic              ptrHiWe,
  input  logic              ptrInc,
  input  logic              pageWe,
  input  logic              selWe,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] ptrValue,
  output logic [BYTE_W-1:0] pageValue,
  output logic [BYTE_W-1:0] selValue
);

  xagStrobe_t                     strobe;
  logic [IDX_W-1:0]               activeIdx;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrAll;

  xag_ctrl #(.BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrData   (wrData),
    .ptrLoWe  (ptrLoWe),
    .ptrHiWe  (ptrHiWe),
    .ptrInc   (ptrInc),
    .pageWe   (pageWe),
    .selWe    (selWe),
    .strobe   (strobe),
    .activeIdx(activeIdx),
    .selValue (selValue)
  );

  xag_datapath #(.BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .activeIdx(activeIdx),
    .wrData   (wrData),
    .addrMode (addrMode),
    .workReg  (workReg),
    .addr     (addr),
    .ptrValue (ptrValue),
    .pageValue(pageValue),
    .ptrAll   (ptrAll)
  );

endmodule

// File: rtl/ext_addr_gen_checker.sv
module ext_addr_gen_checker #(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int ADDR_W = 2 * BYTE_W,
  localparam int IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           addrMode,
  input logic [BYTE_W-1:0]              workReg,
  input logic [BYTE_W-1:0]              wrData,
  input logic                           ptrLoWe,
  input logic                           ptrHiWe,
  input logic                           ptrInc,
  input logic                           pageWe,
  input logic                           selWe,
  input logic [ADDR_W-1:0]              addr,
  input logic [ADDR_W-1:0]              ptrValue,
  input logic [BYTE_W-1:0]              pageValue,
  input logic [BYTE_W-1:0]              selValue,
  input logic [IDX_W-1:0]               activeIdx,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] ptrAll
);

  p_page_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    pageWe |=> (pageValue == $past(wrData)) &&
               (addrMode || (addr == {$past(wrData), workReg})));

  p_ptr_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ptrLoWe && ptrHiWe && !selWe) |=>
      (ptrValue == {$past(wrData), $past(wrData)}) &&
      (!addrMode || (addr == ptrValue)));

  p_sel_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    selWe |=> (selValue[IDX_W-1:0] == $past(wrData[IDX_W-1:0])) &&
              (selValue[BYTE_W-1:IDX_W] == '0));

  p_inc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ptrInc && !ptrLoWe && !ptrHiWe && !selWe) |=>
      (ptrValue == $past(ptrValue) + ADDR_W'(1)));

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (activeIdx != IDX_W'(i)) |=> (ptrAll[i] == $past(ptrAll[i])));
  end

  p_wr_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ptrLoWe && ptrInc && !ptrHiWe && !selWe) |=>
      (ptrValue[BYTE_W-1:0] == $past(wrData)) &&
      (ptrValue[ADDR_W-1:BYTE_W] == $past(ptrValue[ADDR_W-1:BYTE_W])));

endmodule

bind ext_addr_gen ext_addr_gen_checker #(.BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addrMode (addrMode),
  .workReg  (workReg),
  .wrData   (wrData),
  .ptrLoWe  (ptrLoWe),
  .ptrHiWe  (ptrHiWe),
  .ptrInc   (ptrInc),
  .pageWe   (pageWe),
  .selWe    (selWe),
  .addr     (addr),
  .ptrValue (ptrValue),
  .pageValue(pageValue),
  .selValue (selValue),
  .activeIdx(activeIdx),
  .ptrAll   (ptrAll)
);

// File: tb/ext_addr_gen_bench.sv
`timescale 1ns/1ps
module ext_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrMode = 1'b0;
  logic [7:0]  workReg = '0;
  logic [7:0]  wrData = '0;
  logic        ptrLoWe = 1'b0, ptrHiWe = 1'b0, ptrInc = 1'b0;
  logic        pageWe = 1'b0, selWe = 1'b0;
  logic [15:0] addr, ptrValue;
  logic [7:0]  pageValue, selValue;

  int checkCount = 0;
  int failCount  = 0;

  // bench model
  logic [15:0] mPtr [2];
  logic [7:0]  mPage;
  logic        mSel;

  always #2.5 clk = ~clk;

  ext_addr_gen u_ext_addr_gen (
    .clk(clk), .rstN(rstN), .addrMode(addrMode), .workReg(workReg),
    .wrData(wrData), .ptrLoWe(ptrLoWe), .ptrHiWe(ptrHiWe), .ptrInc(ptrInc),
    .pageWe(pageWe), .selWe(selWe), .addr(addr), .ptrValue(ptrValue),
    .pageValue(pageValue), .selValue(selValue)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, update model at the edge, compare after it
  task automatic cyc(input string tag, input bit lo, input bit hi, input bit inc,
                     input bit pg, input bit sl, input logic [7:0] d,
                     input bit mode, input logic [7:0] wr);
    @(negedge clk);
    ptrLoWe = lo; ptrHiWe = hi; ptrInc = inc; pageWe = pg; selWe = sl;
    wrData = d; addrMode = mode; workReg = wr;
    @(posedge clk);
    if (lo || hi) begin
      if (lo) mPtr[mSel][7:0]  = d;
      if (hi) mPtr[mSel][15:8] = d;
    end else if (inc) begin
      mPtr[mSel] = mPtr[mSel] + 16'd1;
    end
    if (pg) mPage = d;
    if (sl) mSel = d[0];
    #1;
    chk({tag, " ptr"},  ptrValue, mPtr[mSel]);
    chk({tag, " page"}, {8'h00, pageValue}, {8'h00, mPage});
    chk({tag, " sel"},  {8'h00, selValue}, {15'h0, mSel});
    chk({tag, " addr"}, addr, mode ? mPtr[mSel] : {mPage, wr});
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    mPtr[0] = '0; mPtr[1] = '0; mPage = '0; mSel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk("R8 ptr",  ptrValue, 16'h0000);
    chk("R8 page", {8'h00, pageValue}, 16'h0000);
    chk("R8 sel",  {8'h00, selValue}, 16'h0000);
    chk("R8 addr", addr, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;

    // R1 / R9: every page value with varied working bytes; pointers untouched
    for (int p = 0; p < 256; p++) begin
      cyc("R9 page write", 0, 0, 0, 1, 0, 8'(p), 0, 8'(p ^ 8'h5A));
      cyc("R1 paged addr", 0, 0, 0, 0, 0, 8'h00, 0, 8'(255 - p));
    end

    // R3: select writes with every data byte
    for (int d = 0; d < 256; d++) begin
      cyc("R3 select", 0, 0, 0, 0, 1, 8'(d), 1, 8'h00);
    end

    // R4 / R2 / R6: load distinct values and toggle
    cyc("R3 sel0",   0, 0, 0, 0, 1, 8'h00, 1, 8'h00);
    cyc("R4 lo p0",  1, 0, 0, 0, 0, 8'h34, 1, 8'h00);
    cyc("R4 hi p0",  0, 1, 0, 0, 0, 8'h12, 1, 8'h00);
    cyc("R3 sel1",   0, 0, 0, 0, 1, 8'h01, 1, 8'h00);
    cyc("R4 both p1",1, 1, 0, 0, 0, 8'hAB, 1, 8'h00);
    cyc("R2 p1",     0, 0, 0, 0, 0, 8'h00, 1, 8'h00);
    cyc("R6 back p0",0, 0, 0, 0, 1, 8'h00, 1, 8'h00);
    chk("R6 p0 kept", ptrValue, 16'h1234);
    cyc("R6 to p1",  0, 0, 0, 0, 1, 8'h01, 1, 8'h00);
    chk("R6 p1 kept", ptrValue, 16'hABAB);

    // R5: increments across low-byte carries on pointer 1
    cyc("R5 ld lo",  1, 0, 0, 0, 0, 8'hF0, 1, 8'h00);
    cyc("R5 ld hi",  0, 1, 0, 0, 0, 8'h00, 1, 8'h00);
    for (int k = 0; k < 300; k++) begin
      cyc("R5 inc", 0, 0, 1, 0, 0, 8'h00, 1, 8'h00);
    end
    chk("R5 after 300", ptrValue, 16'h021C);
    // R5: wrap from 0xFFFF
    cyc("R5 ld ff",  1, 1, 0, 0, 0, 8'hFF, 1, 8'h00);
    cyc("R5 wrap",   0, 0, 1, 0, 0, 8'h00, 1, 8'h00);
    chk("R5 wrap zero", ptrValue, 16'h0000);
    cyc("R6 see p0", 0, 0, 0, 0, 1, 8'h00, 1, 8'h00);
    chk("R6 p0 after incs", ptrValue, 16'h1234);

    // R7: byte write beats increment; select write does not redirect op
    cyc("R7 lo+inc", 1, 0, 1, 0, 0, 8'h77, 1, 8'h00);
    chk("R7 write wins", ptrValue, 16'h1277);
    cyc("R7 sel+ld", 1, 1, 0, 0, 1, 8'h01, 1, 8'h00);
    chk("R7 p1 untouched", ptrValue, 16'h0000);
    cyc("R7 sel+inc",0, 0, 1, 0, 1, 8'h00, 1, 8'h00);
    chk("R7 p0 unchanged", ptrValue, 16'h0101);
    cyc("R7 to p1",  0, 0, 0, 0, 1, 8'h01, 1, 8'h00);
    chk("R7 p1 incremented", ptrValue, 16'h0001);

    // Mixed pseudo-random operation stream (R1..R7, R9)
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R6 mixed", lfsr[0] & lfsr[5], lfsr[1] & lfsr[6], lfsr[2],
          lfsr[3] & lfsr[7], lfsr[4] & lfsr[8], lfsr[15:8], lfsr[9], lfsr[7:0]);
    end

    summary();
  end

endmodule